// File: doc/BRIEF.md
# Edge-Triggered Port Interrupt Unit

This block watches eight asynchronous input pins. Each pin first goes through a two-stage synchroniser. A per-pin polarity bit then chooses whether a rising or a falling level change counts as an event. An event sets a sticky pending bit for that pin. One shared interrupt line is high while any pending bit has its mask bit set.

Software uses a small register bus with four word addresses to program the mask and polarity registers. Over the same bus it reads the pending bits and clears them with a bit mask. Servicing the interrupt never removes a pending bit. The handler reads the pending register to find the source pins and then clears exactly those bits.

Top module: `pint_port`

## Requirements
- R1: After reset the mask, polarity and pending registers read 0 and `irq_o` is low.
- R2: Address 0 reads and writes the mask register, and address 1 reads and writes the polarity register; a write replaces the whole byte. Address 2 reads the pending register, and address 3 reads 0.
- R3: A pin whose polarity bit is 0 sets its pending bit on a 0-to-1 change only. A pin whose polarity bit is 1 sets its pending bit on a 1-to-0 change only. The opposite change sets nothing.
- R4: A level first sampled at clock edge k sets the pending bit at edge k+2. Before that edge, the pending bit reads 0.
- R5: `irq_o` is high exactly when the pending register AND the mask register is non-zero.
- R6: A qualifying change sets its pending bit even while the pin is masked. Writing a 1 to that mask bit raises `irq_o` at the same edge as the write.
- R7: A write to address 2 clears each pending bit whose data bit is 1 and leaves the other pending bits unchanged. No other event clears a pending bit.
- R8: When a qualifying change and a clear of the same bit fall on the same edge, the pending bit ends up set.
- R9: Writing the polarity register while the pin level stays constant sets no pending bit.
- R10: A pin level held through the release of reset sets no pending bit. Change detection starts at the third edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Asynchronous pin levels |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Shared interrupt request |

## Verification
Assertions check four things on every cycle: a pending bit with no clear stays set; no pending bit rises before detection is armed; every new pending bit matches a sampled change in its selected direction; and a zero mask keeps `irq_o` low. Other behaviours can only be shown by the bench's scenarios and its reference model: the exact two-edge latency, an edge and a clear meeting on the same edge, polarity writes that set nothing, and pins held high through reset.

// File: rtl/pint_pkg.sv
package pint_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_MASK = 2'd0,
    REG_POL  = 2'd1,
    REG_PEND = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pint_sync.sv
module pint_sync #(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] d_i,
  output logic [N_PINS-1:0] q_o
);
  logic [N_PINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pint_edge.sv
module pint_edge #(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [N_PINS-1:0] sync_i,
  input  logic [N_PINS-1:0] pol_i,
  input  logic [N_PINS-1:0] clr_i,
  output logic [N_PINS-1:0] pend_o
);
  logic [N_PINS-1:0] prev_q, pend_q, rise, fall, hit;

  assign rise = sync_i & ~prev_q;
  assign fall = ~sync_i & prev_q;
  assign hit  = arm_i ? ((rise & ~pol_i) | (fall & pol_i)) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= sync_i;
      pend_q <= (pend_q & ~clr_i) | hit;  // set wins over clear
    end
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < N_PINS; i++) begin : g_chk
    // R7
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[i] && !clr_i[i]) |=> pend_q[i]);
    // R10
    no_early_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!arm_i && !pend_q[i]) |=> !pend_q[i]);
    // R3
    pend_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q[i]) |-> ($past(sync_i[i]) != $past(prev_q[i]))
                        && ($past(sync_i[i]) == !$past(pol_i[i])));
  end
endmodule

// File: rtl/pint_port.sv
module pint_port
  import pint_pkg::*;
#(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned ARM_AT = STAGES + 1;
  localparam int unsigned ARM_W  = $clog2(ARM_AT + 1);

  logic [N_PINS-1:0] mask_q, pol_q, sync, pend, clr;
  logic [ARM_W-1:0]  arm_cnt_q;
  logic              armed;

  pint_sync #(.N_PINS(N_PINS), .STAGES(STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(sync)
  );

  // hold off detection until the sync chain and history hold real samples
  assign armed = (arm_cnt_q == ARM_W'(ARM_AT));
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_cnt_q <= '0;
    else if (!armed) arm_cnt_q <= arm_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      pol_q  <= '0;
    end else if (wr_i) begin
      if (addr_i == REG_MASK) mask_q <= wdata_i;
      if (addr_i == REG_POL)  pol_q  <= wdata_i;
    end
  end

  assign clr = (wr_i && addr_i == REG_PEND) ? wdata_i : '0;

  pint_edge #(.N_PINS(N_PINS)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(armed), .sync_i(sync),
    .pol_i(pol_q), .clr_i(clr), .pend_o(pend)
  );

  always_comb begin
    unique case (addr_i)
      REG_MASK: rdata_o = mask_q;
      REG_POL:  rdata_o = pol_q;
      REG_PEND: rdata_o = pend;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = |(pend & mask_q);

  // R5
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: tb/pint_port_test.sv
module pint_port_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pin_i = 8'hFF;
  logic       wr_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       irq_o;

  int vecs = 0, errs = 0;
  bit done = 1'b0;

  pint_port uut (.*);

  always #10 clk_i = ~clk_i;

  // behavioural reference
  bit [7:0] hist[$];
  bit [7:0] m_mask, m_pol, m_pend;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist.delete();
      m_mask = 0; m_pol = 0; m_pend = 0;
    end else begin
      bit [7:0] hit, clr;
      hit = 0;
      if (hist.size() >= 3)
        for (int i = 0; i < 8; i++) begin
          bit nw, od;
          nw = hist[1][i]; od = hist[2][i];
          if (m_pol[i] ? (od && !nw) : (!od && nw)) hit[i] = 1;
        end
      clr = (wr_i && addr_i == 2) ? wdata_i : 8'h00;
      m_pend = (m_pend & ~clr) | hit;
      if (wr_i && addr_i == 0) m_mask = wdata_i;
      if (wr_i && addr_i == 1) m_pol = wdata_i;
      hist.push_front(pin_i);
      if (hist.size() > 4) void'(hist.pop_back());
    end
  end

  function automatic bit [7:0] m_rd(input bit [1:0] a);
    case (a)
      2'd0: return m_mask;
      2'd1: return m_pol;
      2'd2: return m_pend;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (rst_ni && !done) begin
    #5;
    chk("R5 irq vs model", irq_o, |(m_pend & m_mask));
    chk("R2 rdata vs model", rdata_o, m_rd(addr_i));
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    @(negedge clk_i);
    wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 0;
  endtask

  task automatic rd_chk(input string tag, input bit [1:0] a, input bit [7:0] exp);
    addr_i = a;
    #5;
    chk(tag, rdata_o, exp);
  endtask

  task automatic report();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    step(3);
    rst_ni = 1;
    step(5);
    // R1 / R10: pins high through reset, nothing pending
    rd_chk("R1 mask", 0, 8'h00);
    rd_chk("R1 pol", 1, 8'h00);
    rd_chk("R10 pend after held-high reset", 2, 8'h00);
    rd_chk("R2 addr3", 3, 8'h00);
    chk("R1 irq", irq_o, 0);
    // R3: falling edges with polarity 0 ignored
    step(); pin_i = 8'h00;
    step(5);
    rd_chk("R3 opposite edge", 2, 8'h00);
    // R3/R4: rising on pin0, latency
    pin_i = 8'h01;
    step(); rd_chk("R4 edge k", 2, 8'h00);
    step(); rd_chk("R4 edge k+1", 2, 8'h00);
    step(); rd_chk("R4 edge k+2", 2, 8'h01);
    // R6: set while masked, enabling raises irq at once
    chk("R6 masked irq", irq_o, 0);
    wr(0, 8'h01);
    #5; chk("R6 irq after enable", irq_o, 1);
    // R7: masked clear
    wr(2, 8'h02);
    rd_chk("R7 other bit kept", 2, 8'h01);
    wr(2, 8'h01);
    rd_chk("R7 cleared", 2, 8'h00);
    chk("R7 irq dropped", irq_o, 0);
    // R3: falling polarity on pin1
    wr(1, 8'h02);
    pin_i = 8'h03; step(5);
    rd_chk("R3 rise ignored on falling pin", 2, 8'h00);
    pin_i = 8'h01; step(4);
    rd_chk("R3 falling sets", 2, 8'h02);
    chk("R5 unmasked pin quiet", irq_o, 0);
    wr(2, 8'hFF);
    // R9: polarity toggles with static level
    wr(1, 8'h06);
    pin_i = 8'h05; step(5);
    for (int t = 0; t < 4; t++) wr(1, t[0] ? 8'h06 : 8'h02);
    step(4);
    rd_chk("R9 polarity write no pend", 2, 8'h00);
    // R8: edge and clear on the same edge
    pin_i = 8'h0D;
    step(); step();
    wr_i = 1; addr_i = 2; wdata_i = 8'h08;
    step();
    wr_i = 0;
    rd_chk("R8 set wins", 2, 8'h08);
    wr(2, 8'h08);
    rd_chk("R8 cleared later", 2, 8'h00);
    // random phase against the model
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk_i);
      if ($urandom_range(0, 3) == 0) pin_i = pin_i ^ 8'($urandom_range(0, 255));
      wr_i = ($urandom_range(0, 3) == 0);
      addr_i = 2'($urandom_range(0, 3));
      wdata_i = 8'($urandom_range(0, 255));
    end
    @(negedge clk_i); wr_i = 0;
    step(2);
    report();
  end
endmodule